// File: doc/BRIEF.md
# Parallel Display Bus Host Controller

This block sits on the host side of a strobe-based parallel bus to a display controller. It accepts one transfer at a time through a request/ready handshake, and each transfer is one of four kinds: a command write, a data write, a fast register/ID read or a slow frame-memory read. For each transfer it lowers chip select, sets the data/command line and drives or releases the data bus. It pulses the write or read strobe and then returns the bus to idle. The bus is 16 bits wide or, by parameter, 8 bits wide.

Every phase length is a whole number of system-clock cycles. Each is derived when the block is elaborated from a minimum time in nanoseconds and the clock period, by ceiling division, and is never below one cycle. Writes, ID reads and frame-memory reads each have their own chip-select setup, strobe-low width and strobe-high recovery. Read data is captured on the clock edge that ends the strobe-low phase.

Each transfer walks through the same states. In ST_IDLE the bus is quiet and a request is accepted. Acceptance moves to ST_SETUP, where chip select is low and the strobe is high. The setup count ending moves to ST_STROBE, where the strobe is low. The low count ending moves to ST_RECOVER, where the strobe is high again and a read is captured on the way in. The recovery count ending moves to ST_HOLD, where chip select is still held. The hold count ending returns to ST_IDLE.

Top module: `pbm_host_bus`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, the bus output enable is low, busy is low, ready is high and the read-valid pulse is low.
- R2: A request with kind 2'b00 (command write) is accepted on a clock edge where ready and valid are both high. The data/command line is then 0 for the whole transfer, and the bus is driven with the request data from the first cycle of chip select until it is released.
- R3: A request with kind 2'b01 (data write) behaves like R2 with the data/command line at 1.
- R4: For a write, chip select leads the write strobe by ceil(15 ns / period) cycles, and the strobe is low for max(ceil(15/p), ceil(10/p)) cycles. Strobe high plus chip-select hold lasts max(ceil(15/p), ceil(10/p), ceil(66/p) − low) + ceil(10/p) cycles. Each ceiling is at least 1. With the 20 ns default these are 1, 1 and 4 cycles.
- R5: For kind 2'b10 (ID read), the setup is ceil(45/p) and the strobe low is max(ceil(45/p), ceil(40/p)). The tail is max(ceil(90/p), ceil(80/p), ceil(160/p) − low) + ceil(10/p). The defaults are 3, 3 and 6 cycles. The output enable stays low throughout.
- R6: For kind 2'b11 (frame-memory read), the setup is ceil(355/p) and the strobe low is max(ceil(355/p), ceil(340/p)). The tail is max(ceil(90/p), ceil(80/p), ceil(450/p) − low) + ceil(10/p). The defaults are 18, 18 and 6 cycles. The output enable stays low throughout.
- R7: Read data is taken from the bus on the edge that ends the strobe-low phase. The read-valid output is high for exactly one cycle, the first cycle with the read strobe high again, and the read data output holds the captured value.
- R8: In 16-bit mode all 16 data lines carry the write data and all 16 input lines are captured on reads.
- R9: In 8-bit mode the upper 8 output lines are always 0, only the low byte of the request data is driven, and the upper byte of captured read data is 0.
- R10: Ready is high only while chip select is high. Busy is high from the cycle after acceptance until the edge that raises chip select, and both change on that same edge.
- R11: A strobe is low only while chip select is low, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 2 | 00 command write, 01 data write, 10 ID read, 11 frame-memory read |
| req_data | input | 16 | Write data (low byte only in 8-bit mode) |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| busy | output | 1 | Transfer in progress, chip select low |
| rd_valid | output | 1 | One-cycle pulse when read data is captured |
| rd_data | output | 16 | Last captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data/command select, 0 for command |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dout | output | 16 | Data toward the display |
| bus_oe | output | 1 | Enable for the bus output drivers |
| bus_din | input | 16 | Data from the display |

## Verification
The embedded properties check, on every cycle, the strobe exclusivity and chip-select coverage, the released bus during a read strobe and the quiet bus whenever the block is ready. They also check that write data stays unchanged while it is driven, that the valid pulse lines up with the read strobe rising, that the upper lines stay zero in 8-bit mode and that no phase count is zero. Only the bench scenarios can show the exact length of each phase for each transfer kind, the data/command level per kind, and that read data is taken at the end of the low phase and not earlier. They also show the masking of the upper byte in 8-bit mode.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [1:0] {
        KIND_CMD_WR = 2'd0,
        KIND_DAT_WR = 2'd1,
        KIND_ID_RD  = 2'd2,
        KIND_FM_RD  = 2'd3
    } pbm_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_HOLD
    } pbm_state_e;

    // Ceiling of a nanosecond minimum over the clock period, at least one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles still owed to a full-cycle minimum once the low phase is spent.
    function automatic int unsigned cycle_rest(input int unsigned total, input int unsigned lo);
        return (total > lo) ? (total - lo) : 1;
    endfunction

endpackage

// File: rtl/pbm_phase_timer.sv
module pbm_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R4

endmodule

// File: rtl/pbm_profile_sel.sv
module pbm_profile_sel
    import pbm_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int CLK_NS    = 20,
    parameter int WR_CYC_NS = 66,
    parameter int WR_LO_NS  = 15,
    parameter int WR_HI_NS  = 15,
    parameter int WR_SU_NS  = 15,
    parameter int D_SU_NS   = 10,
    parameter int D_HO_NS   = 10,
    parameter int ID_SU_NS  = 45,
    parameter int ID_CYC_NS = 160,
    parameter int ID_LO_NS  = 45,
    parameter int ID_HI_NS  = 90,
    parameter int ID_ACC_NS = 40,
    parameter int FM_SU_NS  = 355,
    parameter int FM_CYC_NS = 450,
    parameter int FM_LO_NS  = 355,
    parameter int FM_HI_NS  = 90,
    parameter int FM_ACC_NS = 340,
    parameter int REL_NS    = 80,
    parameter int CS_HO_NS  = 10
) (
    input  pbm_kind_e        kind,
    input  pbm_state_e       phase,
    output logic [CNT_W-1:0] cycles
);

    localparam int unsigned P = CLK_NS;

    localparam int unsigned WR_SU = ns_to_cyc(WR_SU_NS, P);
    localparam int unsigned WR_LO = max2(ns_to_cyc(WR_LO_NS, P), ns_to_cyc(D_SU_NS, P));
    localparam int unsigned WR_HI = max2(max2(ns_to_cyc(WR_HI_NS, P), ns_to_cyc(D_HO_NS, P)),
                                         cycle_rest(ns_to_cyc(WR_CYC_NS, P), WR_LO));

    localparam int unsigned ID_SU = ns_to_cyc(ID_SU_NS, P);
    localparam int unsigned ID_LO = max2(ns_to_cyc(ID_LO_NS, P), ns_to_cyc(ID_ACC_NS, P));
    localparam int unsigned ID_HI = max2(max2(ns_to_cyc(ID_HI_NS, P), ns_to_cyc(REL_NS, P)),
                                         cycle_rest(ns_to_cyc(ID_CYC_NS, P), ID_LO));

    localparam int unsigned FM_SU = ns_to_cyc(FM_SU_NS, P);
    localparam int unsigned FM_LO = max2(ns_to_cyc(FM_LO_NS, P), ns_to_cyc(FM_ACC_NS, P));
    localparam int unsigned FM_HI = max2(max2(ns_to_cyc(FM_HI_NS, P), ns_to_cyc(REL_NS, P)),
                                         cycle_rest(ns_to_cyc(FM_CYC_NS, P), FM_LO));

    localparam int unsigned CS_HO = ns_to_cyc(CS_HO_NS, P);

    always_comb begin
        cycles = CNT_W'(1);
        unique case (phase)
            ST_SETUP: begin
                unique case (kind)
                    KIND_ID_RD: cycles = CNT_W'(ID_SU);
                    KIND_FM_RD: cycles = CNT_W'(FM_SU);
                    default:    cycles = CNT_W'(WR_SU);
                endcase
            end
            ST_STROBE: begin
                unique case (kind)
                    KIND_ID_RD: cycles = CNT_W'(ID_LO);
                    KIND_FM_RD: cycles = CNT_W'(FM_LO);
                    default:    cycles = CNT_W'(WR_LO);
                endcase
            end
            ST_RECOVER: begin
                unique case (kind)
                    KIND_ID_RD: cycles = CNT_W'(ID_HI);
                    KIND_FM_RD: cycles = CNT_W'(FM_HI);
                    default:    cycles = CNT_W'(WR_HI);
                endcase
            end
            ST_HOLD:  cycles = CNT_W'(CS_HO);
            default:  cycles = CNT_W'(1);
        endcase
    end

endmodule

// File: rtl/pbm_data_path.sv
module pbm_data_path #(
    parameter int WIDE_BUS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic [15:0] req_data,
    input  logic        capture,
    input  logic        oe,
    input  logic [15:0] bus_din,
    output logic [15:0] bus_dout,
    output logic [15:0] rd_data,
    output logic        rd_valid
);

    logic [15:0] wdata_q;
    logic [15:0] din_masked;
    logic [15:0] req_masked;

    generate
        if (WIDE_BUS != 0) begin : g_wide
            assign req_masked = req_data;
            assign din_masked = bus_din;
        end else begin : g_narrow
            assign req_masked = {8'h00, req_data[7:0]};
            assign din_masked = {8'h00, bus_din[7:0]};

            AST_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_dout[15:8] == 8'h00) && (rd_data[15:8] == 8'h00)); // R9
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (accept) wdata_q <= req_masked;
            if (capture) rd_data <= din_masked;
            rd_valid <= capture;
        end
    end

    assign bus_dout = wdata_q;

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe)) |-> $stable(bus_dout)); // R2

endmodule

// File: rtl/pbm_fsm.sv
module pbm_fsm
    import pbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  pbm_kind_e  req_kind,
    input  logic       timer_last,
    output logic       load,
    output pbm_state_e load_phase,
    output pbm_kind_e  load_kind,
    output logic       accept,
    output logic       capture,
    output logic       cs_n,
    output logic       dc,
    output logic       wr_n,
    output logic       rd_n,
    output logic       oe,
    output logic       busy,
    output logic       ready
);

    pbm_state_e state, state_nx;
    pbm_kind_e  kind_q;
    logic       is_read;

    assign is_read = (kind_q == KIND_ID_RD) || (kind_q == KIND_FM_RD);
    assign accept  = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= KIND_DAT_WR;
        end else begin
            state <= state_nx;
            if (accept) kind_q <= req_kind;
        end
    end

    always_comb begin
        state_nx   = state;
        load       = 1'b0;
        load_phase = ST_IDLE;
        load_kind  = kind_q;
        capture    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx   = ST_SETUP;
                    load       = 1'b1;
                    load_phase = ST_SETUP;
                    load_kind  = req_kind;
                end
            end
            ST_SETUP: begin
                if (timer_last) begin
                    state_nx   = ST_STROBE;
                    load       = 1'b1;
                    load_phase = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (timer_last) begin
                    state_nx   = ST_RECOVER;
                    load       = 1'b1;
                    load_phase = ST_RECOVER;
                    capture    = is_read;
                end
            end
            ST_RECOVER: begin
                if (timer_last) begin
                    state_nx   = ST_HOLD;
                    load       = 1'b1;
                    load_phase = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (timer_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cs_n  = (state == ST_IDLE);
        dc    = (kind_q != KIND_CMD_WR);
        wr_n  = !((state == ST_STROBE) && !is_read);
        rd_n  = !((state == ST_STROBE) && is_read);
        oe    = (state != ST_IDLE) && !is_read;
        busy  = (state != ST_IDLE);
        ready = (state == ST_IDLE);
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n)); // R11
    AST_STROBE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> !cs_n); // R11
    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !oe); // R5
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && !oe)); // R10

endmodule

// File: rtl/pbm_host_bus.sv
module pbm_host_bus
    import pbm_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int WIDE_BUS  = 1,
    parameter int CNT_W     = 8,
    parameter int WR_CYC_NS = 66,
    parameter int WR_LO_NS  = 15,
    parameter int WR_HI_NS  = 15,
    parameter int WR_SU_NS  = 15,
    parameter int D_SU_NS   = 10,
    parameter int D_HO_NS   = 10,
    parameter int ID_SU_NS  = 45,
    parameter int ID_CYC_NS = 160,
    parameter int ID_LO_NS  = 45,
    parameter int ID_HI_NS  = 90,
    parameter int ID_ACC_NS = 40,
    parameter int FM_SU_NS  = 355,
    parameter int FM_CYC_NS = 450,
    parameter int FM_LO_NS  = 355,
    parameter int FM_HI_NS  = 90,
    parameter int FM_ACC_NS = 340,
    parameter int REL_NS    = 80,
    parameter int CS_HO_NS  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_data,
    output logic        req_ready,
    output logic        busy,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        bus_cs_n,
    output logic        bus_dc,
    output logic        bus_wr_n,
    output logic        bus_rd_n,
    output logic [15:0] bus_dout,
    output logic        bus_oe,
    input  logic [15:0] bus_din
);

    logic             load;
    logic             timer_last;
    logic             accept;
    logic             capture;
    pbm_state_e       load_phase;
    pbm_kind_e        load_kind;
    logic [CNT_W-1:0] load_val;

    pbm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (pbm_kind_e'(req_kind)),
        .timer_last (timer_last),
        .load       (load),
        .load_phase (load_phase),
        .load_kind  (load_kind),
        .accept     (accept),
        .capture    (capture),
        .cs_n       (bus_cs_n),
        .dc         (bus_dc),
        .wr_n       (bus_wr_n),
        .rd_n       (bus_rd_n),
        .oe         (bus_oe),
        .busy       (busy),
        .ready      (req_ready)
    );

    pbm_profile_sel #(
        .CNT_W     (CNT_W),
        .CLK_NS    (CLK_NS),
        .WR_CYC_NS (WR_CYC_NS),
        .WR_LO_NS  (WR_LO_NS),
        .WR_HI_NS  (WR_HI_NS),
        .WR_SU_NS  (WR_SU_NS),
        .D_SU_NS   (D_SU_NS),
        .D_HO_NS   (D_HO_NS),
        .ID_SU_NS  (ID_SU_NS),
        .ID_CYC_NS (ID_CYC_NS),
        .ID_LO_NS  (ID_LO_NS),
        .ID_HI_NS  (ID_HI_NS),
        .ID_ACC_NS (ID_ACC_NS),
        .FM_SU_NS  (FM_SU_NS),
        .FM_CYC_NS (FM_CYC_NS),
        .FM_LO_NS  (FM_LO_NS),
        .FM_HI_NS  (FM_HI_NS),
        .FM_ACC_NS (FM_ACC_NS),
        .REL_NS    (REL_NS),
        .CS_HO_NS  (CS_HO_NS)
    ) u_prof (
        .kind   (load_kind),
        .phase  (load_phase),
        .cycles (load_val)
    );

    pbm_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (timer_last)
    );

    pbm_data_path #(
        .WIDE_BUS (WIDE_BUS)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_data (req_data),
        .capture  (capture),
        .oe       (bus_oe),
        .bus_din  (bus_din),
        .bus_dout (bus_dout),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(bus_rd_n)); // R7
    AST_BUSY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !bus_cs_n); // R10

endmodule

// File: tb/pbm_host_bus_tb_top.sv
module pbm_host_bus_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // wide instance
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_data = '0;
    logic        req_ready, busy, rd_valid;
    logic [15:0] rd_data;
    logic        cs_n, dc, wr_n, rd_n, oe;
    logic [15:0] dout;
    logic [15:0] din = 16'hDEAD;

    // narrow instance
    logic        n_valid = 1'b0;
    logic [1:0]  n_kind = 2'd0;
    logic [15:0] n_data = '0;
    logic        n_ready, n_busy, n_rd_valid;
    logic [15:0] n_rd_data;
    logic        n_cs_n, n_dc, n_wr_n, n_rd_n, n_oe;
    logic [15:0] n_dout;
    logic [15:0] n_din = 16'hFFFF;

    pbm_host_bus dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_ready(req_ready), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .bus_cs_n(cs_n), .bus_dc(dc), .bus_wr_n(wr_n),
        .bus_rd_n(rd_n), .bus_dout(dout), .bus_oe(oe), .bus_din(din)
    );

    pbm_host_bus #(.WIDE_BUS(0)) narrow_i (
        .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_kind(n_kind),
        .req_data(n_data), .req_ready(n_ready), .busy(n_busy), .rd_valid(n_rd_valid),
        .rd_data(n_rd_data), .bus_cs_n(n_cs_n), .bus_dc(n_dc), .bus_wr_n(n_wr_n),
        .bus_rd_n(n_rd_n), .bus_dout(n_dout), .bus_oe(n_oe), .bus_din(n_din)
    );

    // Display model: valid data only in the last low cycle of the read strobe.
    int          model_lo = 1;
    logic [15:0] model_val = '0;
    int          mlow = 0;
    always @(negedge clk) begin
        if (!rd_n) begin
            mlow = mlow + 1;
            din  = (mlow == model_lo) ? model_val : 16'hDEAD;
        end else begin
            mlow = 0;
            din  = 16'hDEAD;
        end
        n_din = !n_rd_n ? 16'hAB5C : 16'hFFFF;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {cs_n, wr_n, rd_n, oe, busy, req_ready, rd_valid},
            {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", {cs_n, wr_n, rd_n, oe, busy, req_ready},
            {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    endtask

    // One transfer on the wide instance with phase measurement.
    task automatic t_xfer(input string rq, input logic [1:0] kind, input logic [15:0] data,
                          input logic [15:0] rval, input int e_su, input int e_lo,
                          input int e_af);
        int su, lo, af, vcnt, vpos, guard;
        bit seen, is_rd, dc_ok, d_ok, oe_ok, bz_ok;
        logic [15:0] vdata;
        logic st;
        su = 0; lo = 0; af = 0; vcnt = 0; vpos = -1; guard = 0; seen = 0;
        dc_ok = 1; d_ok = 1; oe_ok = 1; bz_ok = 1; vdata = '0;
        is_rd = kind[1];
        @(negedge clk);
        model_lo  = e_lo;
        model_val = rval;
        req_valid = 1'b1;
        req_kind  = kind;
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = ~data;
        while (cs_n == 1'b0 && guard < 1000) begin
            st = is_rd ? rd_n : wr_n;
            if (!st) begin lo++; seen = 1; end
            else if (!seen) su++;
            else af++;
            if (rd_valid) begin vcnt++; vpos = af; vdata = rd_data; end
            if (dc !== (kind != 2'd0)) dc_ok = 0;
            if (is_rd) begin if (oe !== 1'b0) oe_ok = 0; end
            else begin
                if (oe !== 1'b1) oe_ok = 0;
                if (dout !== data) d_ok = 0;
            end
            if (busy !== 1'b1 || req_ready !== 1'b0) bz_ok = 0;
            @(negedge clk);
            guard++;
        end
        chk({rq, " setup cycles"}, su, e_su);
        chk({rq, " strobe low cycles"}, lo, e_lo);
        chk({rq, " strobe high plus hold cycles"}, af, e_af);
        chk({rq, " data/command level"}, dc_ok, 1);
        chk({rq, " output enable"}, oe_ok, 1);
        chk("R10 busy high and ready low during transfer", bz_ok, 1);
        chk("R10 idle after chip select release", {busy, req_ready}, 2'b01);
        if (!is_rd) chk("R8 full 16-bit write data on bus", d_ok, 1);
        else begin
            chk("R7 one valid pulse", vcnt, 1);
            chk("R7 valid in first strobe-high cycle", vpos, 1);
            chk("R7 captured data at end of low phase", vdata, rval);
            chk("R7 read data held", rd_data, rval);
        end
    endtask

    task automatic t_cmd_write();
        t_xfer("R2", 2'd0, 16'hC3A1, 16'h0, 1, 1, 4);   // R4 write 1/1/4
    endtask

    task automatic t_data_write();
        t_xfer("R3", 2'd1, 16'hA55A, 16'h0, 1, 1, 4);   // R4
        t_xfer("R4", 2'd1, 16'hFF00, 16'h0, 1, 1, 4);
    endtask

    task automatic t_id_read();
        t_xfer("R5", 2'd2, 16'h0, 16'h85C2, 3, 3, 6);   // 45/20->3, 160/20->8-3=5 +1
    endtask

    task automatic t_fm_read();
        t_xfer("R6", 2'd3, 16'h0, 16'h1E7B, 18, 18, 6); // 355/20->18, 450/20->23-18=5 +1
    endtask

    task automatic t_narrow();
        int guard;
        bit up_ok;
        logic [15:0] got;
        up_ok = 1; guard = 0; got = '0;
        @(negedge clk);
        n_valid = 1'b1; n_kind = 2'd1; n_data = 16'h1234;
        @(negedge clk);
        n_valid = 1'b0;
        while (n_cs_n == 1'b0 && guard < 1000) begin
            if (!n_wr_n && n_dout !== 16'h0034) up_ok = 0;
            @(negedge clk); guard++;
        end
        chk("R9 narrow write drives low byte, upper lines zero", up_ok, 1);
        chk("R9 narrow bus idle upper lines zero", n_dout[15:8], 8'h00);
        guard = 0;
        @(negedge clk);
        n_valid = 1'b1; n_kind = 2'd2;
        @(negedge clk);
        n_valid = 1'b0;
        while (n_cs_n == 1'b0 && guard < 1000) begin
            if (n_rd_valid) got = n_rd_data;
            @(negedge clk); guard++;
        end
        chk("R9 narrow read upper byte masked", got, 16'h005C);
    endtask

    initial begin
        t_reset();
        t_cmd_write();
        t_data_write();
        t_id_read();
        t_fm_read();
        t_cmd_write();
        t_narrow();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule